// File: doc/BRIEF.md
# Ternary Gated-Product Neuron Accumulator

This block evaluates one neuron of a ternary network. Weights and input activations arrive as a stream of rows, one row per clock cycle. Each row carries a fixed number of weight/input pairs. Every pair is multiplied with gated semantics: a zero operand gives zero, equal non-zero operands give +1 and unequal ones give -1. The products of a row are summed and added into a signed accumulator.

A row that is flagged as final closes the neuron. The block subtracts a configured threshold from the total, which includes that final row. A dead-zone activation with a configurable half-width then maps the result to +1, -1 or 0. The result appears, qualified by a valid strobe, on the next cycle, and the accumulator restarts from zero for the next neuron.

A mode input switches the block to binary operation. In that mode operands read as ±1 only, products follow XNOR, and the output is the sign of the total minus the threshold. The threshold and half-width inputs are plain configuration values and are sampled when the final row arrives.

Top module: `tern_neuron_acc`

## Requirements
- R1: A ternary operand code 2'b01 means +1, 2'b11 means -1 and 2'b00 means 0. The unused code 2'b10 is read as 0 in ternary mode. Lane i of a row occupies bits [2i+1:2i] of the weight and input buses.
- R2: In ternary mode a product is 0 when either operand is 0, +1 when both operands are equal non-zero values, and -1 when they are opposite non-zero values.
- R3: On each cycle with `in_valid` high, the sum of all lane products of the row is added to the running total. Cycles with `in_valid` low leave the total unchanged, whatever the data and `in_last` inputs carry.
- R4: A cycle with `in_valid` and `in_last` both high makes `out_valid` high on the following cycle, for exactly one cycle. The result includes that final row.
- R5: In ternary mode, with pre = total - `cfg_thr`, the output is +1 (2'b01) when pre > `cfg_delta`, -1 (2'b11) when pre < -`cfg_delta`, and 0 (2'b00) otherwise.
- R6: In binary mode an operand code of 2'b11 reads as -1 and every other code reads as +1. A product is +1 when the operands are equal and -1 otherwise. The output is +1 when pre >= 0 and -1 when pre < 0, so pre = 0 gives +1. `cfg_delta` has no effect in this mode.
- R7: After a final row the total restarts from zero, so the next neuron's result depends only on its own rows.
- R8: `out_act` reads 2'b00 whenever `out_valid` is low. When `out_valid` is high, `out_act` never carries 2'b10.
- R9: After reset the total is zero and `out_valid` is low.
- R10: A neuron of up to MAX_FANIN pairs (1024 by default) accumulates without overflow, so totals of exactly ±MAX_FANIN are thresholded correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Row qualifier |
| in_last | input | 1 | Marks the final row of a neuron, only used with in_valid |
| bin_mode | input | 1 | 1 selects binary operation, 0 selects ternary |
| in_w | input | 2*LANES | Weight codes of the row, lane i at [2i+1:2i] |
| in_x | input | 2*LANES | Input activation codes of the row, lane i at [2i+1:2i] |
| cfg_thr | input | THR_W | Signed neuron threshold |
| cfg_delta | input | THR_W | Unsigned dead-zone half-width, ternary mode only |
| out_valid | output | 1 | Result strobe, one cycle per neuron |
| out_act | output | 2 | Neuron result code |

## Verification
The assertions assume that `bin_mode`, `cfg_thr` and `cfg_delta` stay constant while a neuron is in progress, and that no neuron carries more than MAX_FANIN pairs. Otherwise the accumulator bound and the binary-mode output check could not be stated. The stimulus changes mode and configuration only after the result of the previous neuron has been seen. Its longest neurons fill exactly 1024 pairs, with every product at the same sign. Idle cycles between rows carry random data and a raised final flag, to show that only qualified rows count.

// File: rtl/tern_pkg.sv
package tern_pkg;

  typedef logic [1:0] tcode_t;

  localparam tcode_t TC_ZERO = 2'b00;
  localparam tcode_t TC_POS  = 2'b01;
  localparam tcode_t TC_BAD  = 2'b10;
  localparam tcode_t TC_NEG  = 2'b11;

  // Operand value: ternary reads 10 as zero, binary reads only 11 as -1
  function automatic logic signed [1:0] tern_val(tcode_t c, logic bin);
    if (bin) begin
      return (c == TC_NEG) ? -2'sd1 : 2'sd1;
    end
    case (c)
      TC_POS:  return 2'sd1;
      TC_NEG:  return -2'sd1;
      default: return 2'sd0;
    endcase
  endfunction

  // Gated XNOR: zero gates the product, otherwise equality gives +1
  function automatic logic signed [1:0] tern_mul(tcode_t a, tcode_t b, logic bin);
    logic signed [1:0] va;
    logic signed [1:0] vb;
    va = tern_val(a, bin);
    vb = tern_val(b, bin);
    if (va == 2'sd0 || vb == 2'sd0) return 2'sd0;
    return (va == vb) ? 2'sd1 : -2'sd1;
  endfunction

  function automatic tcode_t tern_enc(logic signed [1:0] v);
    if (v == 2'sd1)  return TC_POS;
    if (v == -2'sd1) return TC_NEG;
    return TC_ZERO;
  endfunction

endpackage

// File: rtl/tern_row_mac.sv
module tern_row_mac
  import tern_pkg::*;
#(
  parameter int LANES = 4,
  parameter int SUM_W = 4
) (
  input  logic [2*LANES-1:0]       w_row,
  input  logic [2*LANES-1:0]       x_row,
  input  logic                     bin_mode,
  output logic signed [SUM_W-1:0]  row_sum
);

  logic signed [1:0] prod [LANES];

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign prod[i] = tern_mul(tcode_t'(w_row[2*i +: 2]),
                                tcode_t'(x_row[2*i +: 2]), bin_mode);
    end
  endgenerate

  always_comb begin
    row_sum = '0;
    for (int i = 0; i < LANES; i++) begin
      row_sum = row_sum + SUM_W'(prod[i]);
    end
  end

endmodule

// File: rtl/tern_accum.sv
module tern_accum #(
  parameter int ACC_W = 12,
  parameter int SUM_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     in_last,
  input  logic signed [SUM_W-1:0]  row_sum,
  output logic signed [ACC_W-1:0]  acc_q,
  output logic signed [ACC_W-1:0]  total,
  output logic                     fire
);

  assign total = acc_q + ACC_W'(row_sum);
  assign fire  = in_valid & in_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (fire) begin
      acc_q <= '0;
    end else if (in_valid) begin
      acc_q <= total;
    end
  end

endmodule

// File: rtl/tern_activate.sv
module tern_activate
  import tern_pkg::*;
#(
  parameter int ACC_W = 12,
  parameter int THR_W = 16,
  parameter int PRE_W = 17
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fire,
  input  logic                     bin_mode,
  input  logic signed [ACC_W-1:0]  total,
  input  logic signed [THR_W-1:0]  thr,
  input  logic [THR_W-1:0]         delta,
  output logic signed [PRE_W-1:0]  pre_act,
  output logic                     out_valid,
  output tcode_t                   out_act
);

  logic signed [PRE_W-1:0] dlt_s;
  logic signed [1:0]       dir;

  assign pre_act = PRE_W'(total) - PRE_W'(thr);
  assign dlt_s   = PRE_W'(signed'({1'b0, delta}));

  always_comb begin
    if (bin_mode) begin
      dir = pre_act[PRE_W-1] ? -2'sd1 : 2'sd1;
    end else if (pre_act > dlt_s) begin
      dir = 2'sd1;
    end else if (pre_act < -dlt_s) begin
      dir = -2'sd1;
    end else begin
      dir = 2'sd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_act   <= TC_ZERO;
    end else begin
      out_valid <= fire;
      out_act   <= fire ? tern_enc(dir) : TC_ZERO;
    end
  end

endmodule

// File: rtl/tern_neuron_acc.sv
module tern_neuron_acc
  import tern_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int MAX_FANIN = 1024,
  parameter int THR_W     = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     in_last,
  input  logic                     bin_mode,
  input  logic [2*LANES-1:0]       in_w,
  input  logic [2*LANES-1:0]       in_x,
  input  logic signed [THR_W-1:0]  cfg_thr,
  input  logic [THR_W-1:0]         cfg_delta,
  output logic                     out_valid,
  output logic [1:0]               out_act
);

  localparam int SUM_W = $clog2(LANES + 1) + 1;
  localparam int ACC_W = $clog2(MAX_FANIN + 1) + 1;
  localparam int PRE_W = ((ACC_W > THR_W) ? ACC_W : THR_W) + 1;

  logic signed [SUM_W-1:0] row_sum;
  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] total;
  logic signed [PRE_W-1:0] pre_act;
  logic                    fire;
  tcode_t                  act_code;

  tern_row_mac #(.LANES(LANES), .SUM_W(SUM_W)) i_mac (
    .w_row    (in_w),
    .x_row    (in_x),
    .bin_mode (bin_mode),
    .row_sum  (row_sum)
  );

  tern_accum #(.ACC_W(ACC_W), .SUM_W(SUM_W)) i_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_last  (in_last),
    .row_sum  (row_sum),
    .acc_q    (acc_q),
    .total    (total),
    .fire     (fire)
  );

  tern_activate #(.ACC_W(ACC_W), .THR_W(THR_W), .PRE_W(PRE_W)) i_act (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .bin_mode  (bin_mode),
    .total     (total),
    .thr       (cfg_thr),
    .delta     (cfg_delta),
    .pre_act   (pre_act),
    .out_valid (out_valid),
    .out_act   (act_code)
  );

  assign out_act = act_code;

endmodule

// File: rtl/tern_neuron_chk.sv
module tern_neuron_chk #(
  parameter int LANES     = 4,
  parameter int MAX_FANIN = 1024,
  parameter int SUM_W     = 4,
  parameter int ACC_W     = 12
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic                     bin_mode,
  input logic                     fire,
  input logic signed [SUM_W-1:0]  row_sum,
  input logic signed [ACC_W-1:0]  acc_q,
  input logic                     out_valid,
  input logic [1:0]               out_act
);

  localparam logic signed [ACC_W-1:0] ACC_LIM = ACC_W'(MAX_FANIN);
  localparam logic signed [SUM_W-1:0] ROW_LIM = SUM_W'(LANES);

  AST_ROW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (row_sum <= ROW_LIM) && (row_sum >= -ROW_LIM)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(acc_q)); // R3

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid); // R4

  AST_NO_STRAY: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !out_valid); // R4

  AST_BIN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(bin_mode) |-> (out_act == 2'b01 || out_act == 2'b11)); // R6

  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (acc_q == '0)); // R7

  AST_QUIET_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_act == 2'b00)); // R8

  AST_LEGAL_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_act != 2'b10)); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q <= ACC_LIM) && (acc_q >= -ACC_LIM)); // R10

endmodule

bind tern_neuron_acc tern_neuron_chk #(
  .LANES(LANES), .MAX_FANIN(MAX_FANIN), .SUM_W(SUM_W), .ACC_W(ACC_W)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .bin_mode  (bin_mode),
  .fire      (fire),
  .row_sum   (row_sum),
  .acc_q     (acc_q),
  .out_valid (out_valid),
  .out_act   (out_act)
);

// File: tb/test_tern_neuron_acc.sv
module test_tern_neuron_acc;

  localparam int LANES = 4;
  localparam int FANIN = 1024;
  localparam int THR_W = 16;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    in_valid = 1'b0;
  logic                    in_last = 1'b0;
  logic                    bin_mode = 1'b0;
  logic [2*LANES-1:0]      in_w = '0;
  logic [2*LANES-1:0]      in_x = '0;
  logic signed [THR_W-1:0] cfg_thr = '0;
  logic [THR_W-1:0]        cfg_delta = '0;
  logic                    out_valid;
  logic [1:0]              out_act;

  int n_tests = 0;
  int n_fail  = 0;
  int unsigned seed = 32'h1234_5678;

  always #4 clk = ~clk;

  tern_neuron_acc #(.LANES(LANES), .MAX_FANIN(FANIN), .THR_W(THR_W)) i_tern_neuron_acc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
    .bin_mode(bin_mode), .in_w(in_w), .in_x(in_x), .cfg_thr(cfg_thr),
    .cfg_delta(cfg_delta), .out_valid(out_valid), .out_act(out_act)
  );

  function automatic int rnd(int m);
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) % m);
  endfunction

  function automatic int opval(logic [1:0] c, bit bin);
    if (bin) return (c == 2'b11) ? -1 : 1;
    if (c == 2'b01) return 1;
    if (c == 2'b11) return -1;
    return 0;
  endfunction

  function automatic int row_exp(logic [2*LANES-1:0] w, logic [2*LANES-1:0] x, bit bin);
    int s = 0;
    for (int i = 0; i < LANES; i++) s += opval(w[2*i +: 2], bin) * opval(x[2*i +: 2], bin);
    return s;
  endfunction

  function automatic int act_exp(int s, int thr, int dlt, bit bin);
    int pre = s - thr;
    if (bin) return (pre >= 0) ? 1 : -1;
    if (pre > dlt) return 1;
    if (pre < -dlt) return -1;
    return 0;
  endfunction

  function automatic int dec(logic [1:0] c);
    case (c)
      2'b01:   return 1;
      2'b11:   return -1;
      2'b00:   return 0;
      default: return 99;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(logic [2*LANES-1:0] w, logic [2*LANES-1:0] x, bit last);
    @(negedge clk);
    in_w = w; in_x = x; in_valid = 1'b1; in_last = last;
  endtask

  task automatic gap();
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b1;
    in_w = 8'(rnd(256)); in_x = 8'(rnd(256));
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic expect_out(int e, string req);
    idle();
    chk({req, " strobe"}, int'(out_valid), 1);
    chk(req, dec(out_act), e);
    idle();
    chk("R4 single strobe", int'(out_valid), 0);
    chk("R8 quiet output", int'(out_act), 0);
  endtask

  // one row whose ternary sum is s (|s| <= LANES)
  function automatic logic [2*LANES-1:0] mk_w(int s);
    logic [2*LANES-1:0] w = '0;
    for (int i = 0; i < LANES; i++) if (i < ((s < 0) ? -s : s)) w[2*i +: 2] = 2'b01;
    return w;
  endfunction

  function automatic logic [2*LANES-1:0] mk_x(int s);
    logic [2*LANES-1:0] x = '0;
    for (int i = 0; i < LANES; i++) x[2*i +: 2] = (s < 0) ? 2'b11 : 2'b01;
    return x;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset out_valid", int'(out_valid), 0);
    chk("R9 reset out_act", int'(out_act), 0);
    rst_n = 1'b1;
    idle();
    // R9: first neuron starts from a zero total
    cfg_thr = '0; cfg_delta = '0; bin_mode = 1'b0;
    send(mk_w(3), mk_x(3), 1'b1);
    expect_out(1, "R9 first neuron");

    // R1 R2 R6: every code pair in each mode
    for (int b = 0; b < 2; b++) begin
      for (int w = 0; w < 4; w++) begin
        for (int x = 0; x < 4; x++) begin
          logic [2*LANES-1:0] wr = '0;
          logic [2*LANES-1:0] xr = '0;
          int k = (w + x) % LANES;
          if (b == 1) for (int i = 0; i < LANES; i++) begin
            wr[2*i +: 2] = 2'b01; xr[2*i +: 2] = (i % 2 == 0) ? 2'b01 : 2'b11;
          end
          wr[2*k +: 2] = 2'(w); xr[2*k +: 2] = 2'(x);
          bin_mode = b[0];
          send(wr, xr, 1'b1);
          expect_out(act_exp(row_exp(wr, xr, b[0]), 0, 0, b[0]),
                     b ? "R6 binary product" : "R1 R2 ternary product");
        end
      end
    end

    // R5: threshold and dead-zone sweep, R6: delta ignored in binary
    for (int b = 0; b < 2; b++) begin
      for (int s = -LANES; s <= LANES; s++) begin
        for (int t = -2; t <= 2; t++) begin
          for (int d = 0; d <= 2; d++) begin
            bin_mode = 1'b0; cfg_thr = 16'(t); cfg_delta = 16'(d);
            if (b == 1) begin
              bin_mode = 1'b1;
              send(mk_w(LANES), mk_x(s < 0 ? -1 : 1), 1'b0);
              send(mk_w(LANES), mk_x(s < 0 ? 1 : -1), 1'b1);
              expect_out(act_exp(0, t, d, 1'b1), "R6 sign with delta ignored");
            end else begin
              send(mk_w(s), mk_x(s), 1'b1);
              expect_out(act_exp(s, t, d, 1'b0), "R5 dead-zone activation");
            end
          end
        end
      end
    end

    // R3 R7: multi-row neurons with unqualified gap cycles
    for (int n = 0; n < 80; n++) begin
      int rows = 1 + rnd(8);
      int sum = 0;
      bit b = rnd(2) == 1;
      int t = rnd(17) - 8;
      int d = rnd(5);
      bin_mode = b; cfg_thr = 16'(t); cfg_delta = 16'(d);
      for (int r = 0; r < rows; r++) begin
        logic [2*LANES-1:0] wr = 8'(rnd(256));
        logic [2*LANES-1:0] xr = 8'(rnd(256));
        if (rnd(3) == 0) gap();
        sum += row_exp(wr, xr, b);
        send(wr, xr, r == rows - 1);
      end
      expect_out(act_exp(sum, t, d, b), "R3 R7 accumulate and restart");
    end

    // R10: full fan-in at both extremes
    for (int c = 0; c < 4; c++) begin
      int s = (c % 2 == 0) ? FANIN : -FANIN;
      int t = (c < 2) ? s : s - 1;
      bin_mode = (c % 2 == 1); cfg_thr = 16'(t); cfg_delta = '0;
      for (int r = 0; r < FANIN / LANES; r++)
        send(mk_w(LANES), mk_x(s < 0 ? -1 : 1), r == FANIN / LANES - 1);
      expect_out(act_exp(s, t, 0, c % 2 == 1), "R10 full fan-in");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule